// File: doc/BRIEF.md
# LPC Firmware Memory Cycle Target

This block sits on the target side of a Low Pin Count bus. It answers single-byte firmware memory read and write cycles. It follows the active-low frame strobe and the 4-bit multiplexed LAD bus. While the strobe is low it keeps the latest nibble as the cycle code, and it claims a cycle only when three things agree: the code, a 4-bit device-select strap and a byte-sized transfer field. After that it collects the address, and for writes the data byte. It waits out the host turnaround and reports progress with SYNC codes. It then returns the read byte or finishes the write, and hands LAD back to the host.

On the storage side there is a plain synchronous byte port. The block raises a one-clock write or read strobe with address and write data. The storage answers with a ready pulse, which may arrive in that same clock or any later one. Until ready arrives the block sends wait SYNC codes, so the storage latency sets how long the bus cycle lasts. The block drives LAD only through a separate output-enable. A standby flag reports when the frame strobe is high and no cycle is active.

Top module: `lpc_fw_target`

## Requirements
- R1: The cycle code is the LAD nibble sampled on the last clock of a run of one or more low frame-strobe clocks. Code 4'b1101 starts a read and 4'b1110 starts a write. Earlier nibbles of the same run have no effect.
- R2: Any other cycle code is ignored. LAD is never enabled, no storage strobe is raised, and the block idles until the strobe falls again.
- R3: The nibble after the code is compared with `id_strap`. On a mismatch the cycle is not claimed and nothing is driven or strobed.
- R4: Seven address nibbles follow, most significant first, and `mem_addr` carries that 28-bit value while the storage strobe is high. The next nibble must be 4'b0000, otherwise the cycle is not claimed.
- R5: On a write, two data nibbles follow, low nibble first. `mem_wr` is high for exactly one clock, the first host-turnaround clock after the high nibble, with the assembled byte on `mem_wdata`.
- R6: On a read, `mem_rd` is high for exactly one clock, the first host-turnaround clock after the size nibble.
- R7: After two host-turnaround clocks the block drives SYNC. It sends 4'b0101 while the storage has not yet given `mem_ready`, then one 4'b0000. `mem_ready` counts from the strobe clock onward, so a ready seen in the strobe clock or the clock after it gives no wait codes at all.
- R8: On a read, SYNC 4'b0000 is followed by the data low nibble, the data high nibble, one clock of 4'b1111, and then LAD is released.
- R9: On a write, SYNC 4'b0000 is followed by one clock of 4'b1111, then LAD is released and the block is idle.
- R10: `lad_oe` is high only in SYNC, read-data and target 4'b1111 turnaround clocks. It is low during every host-driven field and every storage-strobe clock.
- R11: A low frame strobe on any clock aborts the current cycle. LAD is released in the next clock, and the nibble becomes a new cycle code.
- R12: `standby` is high exactly when the frame strobe is high and no cycle is in progress.
- R13: After reset the block is idle with `lad_oe`, `mem_wr` and `mem_rd` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; everything samples on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_n | input | 1 | Active-low frame strobe from the host |
| lad_in | input | 4 | LAD value as seen on the bus |
| lad_out | output | 4 | LAD value driven by the target |
| lad_oe | output | 1 | Output-enable for `lad_out` |
| id_strap | input | 4 | Device-select value this target answers to |
| standby | output | 1 | High when the strobe is high and the block is idle |
| mem_addr | output | ADDR_W | Collected byte address |
| mem_wdata | output | 8 | Write byte for the storage |
| mem_wr | output | 1 | One-clock write request |
| mem_rd | output | 1 | One-clock read request |
| mem_rdata | input | 8 | Read byte, taken in the clock `mem_ready` is seen |
| mem_ready | input | 1 | Storage completion pulse |

## Verification
A wrong phase or a wrong field counter soon shows up at the ports, because the SYNC code comes at a fixed clock offset from the size nibble. If the position is off by one, the first SYNC sample shows `lad_oe` low, or a request strobe appears one clock early or late. A completion flag that is stale or stuck gives too many or too few 4'b0101 codes, and a latched read byte that is wrong shows in the two data clocks that follow at once. A broken abort path shows on the first clock after the frame strobe falls: `lad_oe` stays high there.

// File: rtl/lpc_fw_pkg.sv
package lpc_fw_pkg;

   typedef enum logic [3:0] {
      PH_IDLE,
      PH_FRAMED,
      PH_ADDR,
      PH_MSIZE,
      PH_WLO,
      PH_WHI,
      PH_HTAR1,
      PH_HTAR2,
      PH_SYNC,
      PH_RLO,
      PH_RHI,
      PH_TTAR1,
      PH_TTAR2
   } fw_phase_t;

   localparam logic [3:0] NIB_CODE_RD   = 4'b1101;
   localparam logic [3:0] NIB_CODE_WR   = 4'b1110;
   localparam logic [3:0] NIB_SIZE_BYTE = 4'b0000;
   localparam logic [3:0] NIB_SYNC_WAIT = 4'b0101;
   localparam logic [3:0] NIB_SYNC_OK   = 4'b0000;
   localparam logic [3:0] NIB_TURN      = 4'b1111;

endpackage

// File: rtl/lpc_fw_code_latch.sv
module lpc_fw_code_latch
   import lpc_fw_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       frame_n,
   input  logic [3:0] lad_in,
   output logic       code_rd,
   output logic       code_wr
);

   logic [3:0] code_q;

   // every low-strobe clock overwrites; the last one wins
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        code_q <= 4'h0;
      else if (!frame_n) code_q <= lad_in;
   end

   assign code_rd = (code_q == NIB_CODE_RD);
   assign code_wr = (code_q == NIB_CODE_WR);

endmodule

// File: rtl/lpc_fw_addr_chain.sv
module lpc_fw_addr_chain #(
   parameter int NIBBLES = 7,
   localparam int W = 4 * NIBBLES
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         shift_en,
   input  logic [3:0]   lad_in,
   output logic [W-1:0] addr
);

   logic [3:0] nib [NIBBLES];

   for (genvar i = 0; i < NIBBLES; i++) begin : g_nib
      if (i == 0) begin : g_head
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        nib[i] <= 4'h0;
            else if (shift_en) nib[i] <= lad_in;
         end
      end else begin : g_body
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        nib[i] <= 4'h0;
            else if (shift_en) nib[i] <= nib[i-1];
         end
      end
      assign addr[4*i +: 4] = nib[i];
   end

endmodule

// File: rtl/lpc_fw_seq.sv
module lpc_fw_seq
   import lpc_fw_pkg::*;
#(
   parameter int NIBBLES = 7,
   localparam int CW = $clog2(NIBBLES + 1)
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       frame_n,
   input  logic [3:0] lad_in,
   input  logic [3:0] id_strap,
   input  logic       code_rd,
   input  logic       code_wr,
   input  logic       op_done,
   output fw_phase_t  phase,
   output logic       dir_wr,
   output logic       addr_shift,
   output logic       cap_lo,
   output logic       cap_hi
);

   localparam logic [CW-1:0] LAST_NIB = CW'(NIBBLES - 1);

   fw_phase_t     nxt;
   logic          nxt_wr;
   logic [CW-1:0] cnt, nxt_cnt;

   always_comb begin
      nxt     = phase;
      nxt_wr  = dir_wr;
      nxt_cnt = cnt;
      if (!frame_n) begin
         nxt = PH_FRAMED;
      end else begin
         case (phase)
            PH_IDLE:   nxt = PH_IDLE;
            PH_FRAMED: begin
               if ((code_rd || code_wr) && (lad_in == id_strap)) begin
                  nxt     = PH_ADDR;
                  nxt_wr  = code_wr;
                  nxt_cnt = '0;
               end else begin
                  nxt = PH_IDLE;
               end
            end
            PH_ADDR: begin
               if (cnt == LAST_NIB) nxt = PH_MSIZE;
               else                 nxt_cnt = cnt + 1'b1;
            end
            PH_MSIZE: begin
               if (lad_in != NIB_SIZE_BYTE) nxt = PH_IDLE;
               else if (dir_wr)             nxt = PH_WLO;
               else                         nxt = PH_HTAR1;
            end
            PH_WLO:   nxt = PH_WHI;
            PH_WHI:   nxt = PH_HTAR1;
            PH_HTAR1: nxt = PH_HTAR2;
            PH_HTAR2: nxt = PH_SYNC;
            PH_SYNC:  if (op_done) nxt = dir_wr ? PH_TTAR1 : PH_RLO;
            PH_RLO:   nxt = PH_RHI;
            PH_RHI:   nxt = PH_TTAR1;
            PH_TTAR1: nxt = PH_TTAR2;
            PH_TTAR2: nxt = PH_IDLE;
            default:  nxt = PH_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase  <= PH_IDLE;
         dir_wr <= 1'b0;
         cnt    <= '0;
      end else begin
         phase  <= nxt;
         dir_wr <= nxt_wr;
         cnt    <= nxt_cnt;
      end
   end

   assign addr_shift = frame_n && (phase == PH_ADDR);
   assign cap_lo     = frame_n && (phase == PH_WLO);
   assign cap_hi     = frame_n && (phase == PH_WHI);

endmodule

// File: rtl/lpc_fw_port_ctl.sv
module lpc_fw_port_ctl
   import lpc_fw_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  fw_phase_t  phase,
   input  logic       dir_wr,
   input  logic       cap_lo,
   input  logic       cap_hi,
   input  logic [3:0] lad_in,
   input  logic       mem_ready,
   input  logic [7:0] mem_rdata,
   output logic       op_done,
   output logic [7:0] rd_byte,
   output logic [7:0] wr_byte,
   output logic       mem_wr,
   output logic       mem_rd
);

   logic in_strobe, in_wait;

   assign in_strobe = (phase == PH_HTAR1);
   assign in_wait   = (phase == PH_HTAR2) || (phase == PH_SYNC);
   assign mem_wr    = in_strobe && dir_wr;
   assign mem_rd    = in_strobe && !dir_wr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op_done <= 1'b0;
         rd_byte <= 8'h00;
      end else if (in_strobe) begin
         op_done <= mem_ready;
         if (mem_ready && !dir_wr) rd_byte <= mem_rdata;
      end else if (in_wait && !op_done && mem_ready) begin
         op_done <= 1'b1;
         if (!dir_wr) rd_byte <= mem_rdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_byte <= 8'h00;
      end else begin
         if (cap_lo) wr_byte[3:0] <= lad_in;
         if (cap_hi) wr_byte[7:4] <= lad_in;
      end
   end

endmodule

// File: rtl/lpc_fw_lad_drive.sv
module lpc_fw_lad_drive
   import lpc_fw_pkg::*;
(
   input  fw_phase_t  phase,
   input  logic       op_done,
   input  logic [7:0] rd_byte,
   output logic [3:0] lad_out,
   output logic       lad_oe
);

   always_comb begin
      lad_oe  = 1'b1;
      lad_out = NIB_TURN;
      case (phase)
         PH_SYNC:  lad_out = op_done ? NIB_SYNC_OK : NIB_SYNC_WAIT;
         PH_RLO:   lad_out = rd_byte[3:0];
         PH_RHI:   lad_out = rd_byte[7:4];
         PH_TTAR1: lad_out = NIB_TURN;
         default:  lad_oe  = 1'b0;
      endcase
   end

endmodule

// File: rtl/lpc_fw_target.sv
module lpc_fw_target
   import lpc_fw_pkg::*;
#(
   parameter int ADDR_NIBBLES = 7,
   localparam int ADDR_W = 4 * ADDR_NIBBLES
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_n,
   input  logic [3:0]        lad_in,
   output logic [3:0]        lad_out,
   output logic              lad_oe,
   input  logic [3:0]        id_strap,
   output logic              standby,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [7:0]        mem_wdata,
   output logic              mem_wr,
   output logic              mem_rd,
   input  logic [7:0]        mem_rdata,
   input  logic              mem_ready
);

   if (ADDR_NIBBLES < 1 || ADDR_NIBBLES > 8) begin : g_bad_cfg
      $error("lpc_fw_target: ADDR_NIBBLES must lie in 1..8");
   end

   fw_phase_t  phase;
   logic       code_rd, code_wr;
   logic       dir_wr, addr_shift, cap_lo, cap_hi;
   logic       op_done;
   logic [7:0] rd_byte;

   lpc_fw_code_latch u_code (
      .clk     (clk),
      .rst_n   (rst_n),
      .frame_n (frame_n),
      .lad_in  (lad_in),
      .code_rd (code_rd),
      .code_wr (code_wr)
   );

   lpc_fw_seq #(.NIBBLES(ADDR_NIBBLES)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .frame_n    (frame_n),
      .lad_in     (lad_in),
      .id_strap   (id_strap),
      .code_rd    (code_rd),
      .code_wr    (code_wr),
      .op_done    (op_done),
      .phase      (phase),
      .dir_wr     (dir_wr),
      .addr_shift (addr_shift),
      .cap_lo     (cap_lo),
      .cap_hi     (cap_hi)
   );

   lpc_fw_addr_chain #(.NIBBLES(ADDR_NIBBLES)) u_addr (
      .clk      (clk),
      .rst_n    (rst_n),
      .shift_en (addr_shift),
      .lad_in   (lad_in),
      .addr     (mem_addr)
   );

   lpc_fw_port_ctl u_port (
      .clk       (clk),
      .rst_n     (rst_n),
      .phase     (phase),
      .dir_wr    (dir_wr),
      .cap_lo    (cap_lo),
      .cap_hi    (cap_hi),
      .lad_in    (lad_in),
      .mem_ready (mem_ready),
      .mem_rdata (mem_rdata),
      .op_done   (op_done),
      .rd_byte   (rd_byte),
      .wr_byte   (mem_wdata),
      .mem_wr    (mem_wr),
      .mem_rd    (mem_rd)
   );

   lpc_fw_lad_drive u_drive (
      .phase   (phase),
      .op_done (op_done),
      .rd_byte (rd_byte),
      .lad_out (lad_out),
      .lad_oe  (lad_oe)
   );

   assign standby = frame_n && (phase == PH_IDLE);

endmodule

// File: rtl/lpc_fw_target_chk.sv
module lpc_fw_target_chk (
   input logic clk,
   input logic rst_n,
   input logic frame_n,
   input logic lad_oe,
   input logic standby,
   input logic mem_wr,
   input logic mem_rd
);

   // R5 / R6: a request is a single-clock pulse
   p_wr_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr |=> !mem_wr);
   p_rd_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd |=> !mem_rd);
   p_one_dir_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_wr && mem_rd));

   // R10: the target never drives during a request clock or the clock after
   p_strobe_no_drive_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wr || mem_rd) |-> !lad_oe);
   p_strobe_then_host_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wr || mem_rd) |=> !lad_oe);

   // R11: a low strobe releases LAD on the following clock
   p_abort_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_n |=> !lad_oe);

   // R12: standby only with the strobe high and nothing active
   p_standby_strobe_r12: assert property (@(posedge clk) disable iff (!rst_n)
      standby |-> frame_n);
   p_standby_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
      standby |-> (!lad_oe && !mem_wr && !mem_rd));

endmodule

bind lpc_fw_target lpc_fw_target_chk u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .frame_n (frame_n),
   .lad_oe  (lad_oe),
   .standby (standby),
   .mem_wr  (mem_wr),
   .mem_rd  (mem_rd)
);

// File: tb/tb_lpc_fw_target.sv
`timescale 1ns/1ps
module tb_lpc_fw_target;

   localparam int AN = 7;
   localparam logic [3:0] STRAP = 4'hA;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          frame_n;
   logic [3:0]    lad_in;
   logic [3:0]    lad_out;
   logic          lad_oe;
   logic [3:0]    id_strap;
   logic          standby;
   logic [4*AN-1:0] mem_addr;
   logic [7:0]    mem_wdata;
   logic          mem_wr, mem_rd;
   logic [7:0]    mem_rdata;
   logic          mem_ready;

   int n_cmp = 0;
   int n_bad = 0;
   bit done_flag = 0;

   always #10 clk = ~clk;

   lpc_fw_target #(.ADDR_NIBBLES(AN)) dut (
      .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .lad_in(lad_in),
      .lad_out(lad_out), .lad_oe(lad_oe), .id_strap(id_strap),
      .standby(standby), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_wr(mem_wr), .mem_rd(mem_rd), .mem_rdata(mem_rdata),
      .mem_ready(mem_ready)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done_flag) begin
         done_flag = 1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   // called at a falling edge; drives, crosses one rising edge, returns at the next falling edge
   task automatic tick(input logic f, input logic [3:0] l, input logic rdy);
      frame_n   = f;
      lad_in    = l;
      mem_ready = rdy;
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic run_cycle(input logic [3:0] st, input logic [3:0] ids,
                            input logic [27:0] ad, input logic [3:0] ms,
                            input logic [7:0] wb, input logic [7:0] rb,
                            input int nfr, input int lat);
      logic  is_rd, is_wr, claim;
      string req;
      int    k, waits;
      is_rd = (st == 4'b1101);
      is_wr = (st == 4'b1110);
      claim = (is_rd || is_wr) && (ids == STRAP) && (ms == 4'b0000);
      for (int i = 0; i < nfr; i++) begin
         tick(1'b0, (i == nfr - 1) ? st : 4'($urandom), 1'b0);
         chk("R11", "oe while framed", 32'(lad_oe), 0);
         chk("R12", "standby while framed", 32'(standby), 0);
      end
      tick(1'b1, ids, 1'b0);
      for (int i = AN - 1; i >= 0; i--) tick(1'b1, ad[4*i +: 4], 1'b0);
      tick(1'b1, ms, 1'b0);
      if (!claim) begin
         if (!(is_rd || is_wr))   req = "R2";
         else if (ids != STRAP)   req = "R3";
         else                     req = "R4";
         for (int i = 0; i < 8; i++) begin
            chk(req, "oe unclaimed", 32'(lad_oe), 0);
            chk(req, "strobe unclaimed", 32'(mem_wr | mem_rd), 0);
            tick(1'b1, 4'hF, 1'b0);
         end
         chk("R12", "standby after unclaimed", 32'(standby), 1);
         return;
      end
      if (is_wr) begin
         tick(1'b1, wb[3:0], 1'b0);
         chk("R10", "oe in write data", 32'(lad_oe), 0);
         tick(1'b1, wb[7:4], 1'b0);
      end
      // first host turnaround clock: request strobe
      chk("R1", "direction mem_wr", 32'(mem_wr), 32'(is_wr));
      chk(is_wr ? "R5" : "R6", "request strobe", 32'(mem_wr | mem_rd), 1);
      chk("R4", "address", 32'(mem_addr), 32'(ad));
      if (is_wr) chk("R5", "write byte", 32'(mem_wdata), 32'(wb));
      chk("R10", "oe in strobe clock", 32'(lad_oe), 0);
      mem_rdata = rb;
      k = 0;
      tick(1'b1, 4'hF, k == lat); k++;
      chk(is_wr ? "R5" : "R6", "strobe single clock", 32'(mem_wr | mem_rd), 0);
      chk("R10", "oe in host turnaround", 32'(lad_oe), 0);
      tick(1'b1, 4'hF, k == lat); k++;
      waits = (lat > 1) ? lat - 1 : 0;
      for (int w = 0; w < 64; w++) begin
         chk("R10", "oe in sync", 32'(lad_oe), 1);
         chk("R7", "sync code", 32'(lad_out), (w < waits) ? 32'h5 : 32'h0);
         tick(1'b1, 4'hF, k == lat); k++;
         if (w >= waits) break;
      end
      mem_rdata = 8'($urandom);
      if (is_rd) begin
         chk("R8", "read low nibble", 32'(lad_out), 32'(rb[3:0]));
         chk("R8", "oe read low", 32'(lad_oe), 1);
         tick(1'b1, 4'hF, 1'b0);
         chk("R8", "read high nibble", 32'(lad_out), 32'(rb[7:4]));
         chk("R8", "oe read high", 32'(lad_oe), 1);
         tick(1'b1, 4'hF, 1'b0);
      end
      chk(is_wr ? "R9" : "R8", "target turnaround value", 32'(lad_out), 32'hF);
      chk(is_wr ? "R9" : "R8", "target turnaround oe", 32'(lad_oe), 1);
      tick(1'b1, 4'hF, 1'b0);
      chk(is_wr ? "R9" : "R8", "released", 32'(lad_oe), 0);
      tick(1'b1, 4'hF, 1'b0);
      chk("R12", "standby after cycle", 32'(standby), 1);
      chk("R10", "oe idle", 32'(lad_oe), 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      finish_run();
   end

   initial begin
      logic [3:0] st, ids, ms;
      int kind;
      void'($urandom(32'h1DEC0DE5));
      rst_n = 1'b0; frame_n = 1'b1; lad_in = 4'hF; id_strap = STRAP;
      mem_rdata = 8'h00; mem_ready = 1'b0;
      repeat (3) @(negedge clk);
      // R13: reset state
      chk("R13", "oe in reset", 32'(lad_oe), 0);
      chk("R13", "strobes in reset", 32'(mem_wr | mem_rd), 0);
      rst_n = 1'b1;
      tick(1'b1, 4'hF, 1'b0);
      chk("R13", "oe after reset", 32'(lad_oe), 0);
      chk("R12", "standby after reset", 32'(standby), 1);

      // directed: plain write and read, zero and long latency
      run_cycle(4'b1110, STRAP, 28'h1234567, 4'h0, 8'hA5, 8'h00, 1, 0);
      run_cycle(4'b1101, STRAP, 28'hFEDCBA9, 4'h0, 8'h00, 8'h3C, 1, 5);
      // R1: long strobe, earlier write code superseded by a read code
      tick(1'b0, 4'b1110, 1'b0);
      run_cycle(4'b1101, STRAP, 28'h0000001, 4'h0, 8'h00, 8'hF0, 2, 1);
      // R2 / R3 / R4: unclaimed variants
      run_cycle(4'b0000, STRAP, 28'h0ABCDEF, 4'h0, 8'h11, 8'h22, 1, 0);
      run_cycle(4'b1110, 4'h3,  28'h0ABCDEF, 4'h0, 8'h11, 8'h22, 1, 0);
      run_cycle(4'b1101, STRAP, 28'h0ABCDEF, 4'h1, 8'h11, 8'h22, 1, 0);

      // R11: abort while the target waits in SYNC
      tick(1'b0, 4'b1101, 1'b0);
      tick(1'b1, STRAP, 1'b0);
      for (int i = 0; i < AN; i++) tick(1'b1, 4'h7, 1'b0);
      tick(1'b1, 4'h0, 1'b0);
      tick(1'b1, 4'hF, 1'b0);
      tick(1'b1, 4'hF, 1'b0);
      chk("R7", "wait sync before abort", 32'(lad_out), 32'h5);
      chk("R10", "oe before abort", 32'(lad_oe), 1);
      run_cycle(4'b1110, STRAP, 28'h5555AAA, 4'h0, 8'h69, 8'h00, 1, 2);
      // R11: abort in the middle of the address
      tick(1'b0, 4'b1110, 1'b0);
      tick(1'b1, STRAP, 1'b0);
      for (int i = 0; i < 3; i++) tick(1'b1, 4'h9, 1'b0);
      run_cycle(4'b1101, STRAP, 28'h7654321, 4'h0, 8'h00, 8'h81, 1, 3);

      // constrained random mix
      for (int n = 0; n < 60; n++) begin
         kind = $urandom_range(0, 9);
         if (kind < 4)      st = 4'b1101;
         else if (kind < 8) st = 4'b1110;
         else begin
            st = 4'($urandom);
            while (st == 4'b1101 || st == 4'b1110) st = 4'($urandom);
         end
         ids = ($urandom_range(0, 7) == 0) ? 4'($urandom) : STRAP;
         ms  = ($urandom_range(0, 7) == 0) ? 4'($urandom) : 4'h0;
         run_cycle(st, ids, 28'($urandom), ms, 8'($urandom), 8'($urandom),
                   $urandom_range(1, 3), $urandom_range(0, 5));
         for (int g = 0; g < int'($urandom_range(0, 2)); g++) tick(1'b1, 4'hF, 1'b0);
      end
      finish_run();
   end

endmodule